// File: doc/BRIEF.md
# Training-Pattern Byte Aligner

This block sits behind a 1:8 serial-to-parallel converter on one receive lane. The converter delivers 8-bit words whose boundaries fall at an unknown bit position relative to the transmitted bytes. Bit-level phase alignment happens before this block. After that, the system raises a dedicated alignment request, and the transmitter sends a repeated byte-alignment training word.

The aligner examines every one-bit shift of the last two received words. It keeps a candidate shift only while that shift keeps reproducing the training word. It locks once the same shift has matched on three consecutive words. From then on it emits correctly framed bytes with a valid flag, all in the single system clock domain.

Each receive lane gets its own instance. The locked shift is held until the next alignment request.

Top module: `byte_aligner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `aligned` and `dout_vld` are 0. After reset the block is idle and produces no output until an alignment request has been made and a lock achieved.
- R2: The received stream is taken MSB first, and each word follows the previous valid word. For shift k (0..7), the candidate byte is bits k+7..k of the 15-bit value {previous word[6:0], current word}. The training word is 8'hF0.
- R3: While searching, `aligned` rises on the cycle after the third consecutive valid word on which the same shift reproduces 8'hF0. It stays 0 after the first and second such words.
- R4: `dout_vld` is never 1 unless `aligned` was 1 on the previous cycle. No byte is produced while idle or searching.
- R5: While aligned, each valid input word yields `dout_vld`=1 one cycle later. `dout` then holds the candidate byte at the locked shift, which equals the transmitted byte.
- R6: Once aligned, the locked shift does not change, even if the data contains 8'hF0 at another shift.
- R7: An `align_req` cycle clears `aligned` on the next cycle and restarts the search. A word presented in the same cycle as the request produces no output and does not count toward a lock.
- R8: A valid word on which the candidate shift does not reproduce 8'hF0 discards the run. A fresh run of three matches is then needed.
- R9: Cycles with `din_vld`=0 neither advance nor break a run, and they produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_req | input | 1 | Starts a new byte-alignment search |
| din_vld | input | 1 | Qualifies `din` |
| din | input | 8 | Deserialized word with arbitrary bit offset |
| dout_vld | output | 1 | Framed byte is valid |
| dout | output | 8 | Framed byte |
| aligned | output | 1 | A shift is locked |

## Verification
An alignment request and a valid data word can arrive in the same cycle while the block is locked. The bench provokes this by driving a data word together with `align_req`, and it queues no expected byte for that word. It then judges that no byte is ever emitted for that word and that `aligned` reads 0 on the following cycle. The same word is kept in the stream, so the bench can also show that the following search still locks at the correct shift.

// File: rtl/byte_aligner.sv
module byte_aligner #(
  parameter int W = 8,
  parameter logic [W-1:0] TRAIN = 8'hF0,
  parameter int LOCK = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         align_req,
  input  logic         din_vld,
  input  logic [W-1:0] din,
  output logic         dout_vld,
  output logic [W-1:0] dout,
  output logic         aligned
);
  localparam int OW = $clog2(W);
  localparam int CW = $clog2(LOCK + 1);

  logic [W-1:0]    prev_q;
  logic [2*W-2:0]  cat;
  logic [W-1:0]    win [W];
  logic [W-1:0]    hit;
  logic [OW-1:0]   first, cand, offset;
  logic [CW-1:0]   cnt;
  logic            searching;

  assign cat = {prev_q[W-2:0], din};

  for (genvar k = 0; k < W; k++) begin : g_win
    assign win[k] = cat[k+W-1:k];
    assign hit[k] = (win[k] == TRAIN);
  end

  always_comb begin
    first = '0;
    for (int k = W - 1; k >= 0; k--)
      if (hit[k]) first = OW'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      dout      <= '0;
      dout_vld  <= 1'b0;
      aligned   <= 1'b0;
      searching <= 1'b0;
      cnt       <= '0;
      cand      <= '0;
      offset    <= '0;
    end else begin
      dout_vld <= 1'b0;
      if (din_vld) prev_q <= din;
      if (align_req) begin
        aligned   <= 1'b0;
        searching <= 1'b1;
        cnt       <= '0;
      end else if (din_vld) begin
        if (aligned) begin
          dout     <= win[offset];
          dout_vld <= 1'b1;
        end else if (searching) begin
          if (cnt != '0 && hit[cand]) begin
            if (cnt == CW'(LOCK - 1)) begin
              aligned   <= 1'b1;
              searching <= 1'b0;
              offset    <= cand;
              cnt       <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (|hit) begin
            cand <= first;
            cnt  <= CW'(1);
          end else begin
            cnt <= '0;
          end
        end
      end
    end
  end

  p_req_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_req |=> !aligned && !dout_vld);

  p_vld_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(aligned));

  p_lock_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(cnt) == CW'(LOCK - 1) && $past(din_vld));

  p_offset_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aligned && !align_req |=> $stable(offset) && aligned);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOCK - 1));

  p_gap_neutral_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld && !align_req |=> $stable(cnt) && $stable(aligned) && !dout_vld);
endmodule

// File: tb/byte_aligner_bench.sv
module byte_aligner_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic align_req = 1'b0;
  logic din_vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic dout_vld;
  logic [7:0] dout;
  logic aligned;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit q[$];
  logic [7:0] expq[$];
  bit exp_on = 0;
  logic [7:0] last_tx = 8'h00;

  always #2 clk = ~clk;

  byte_aligner u_byte_aligner (
    .clk(clk), .rst_n(rst_n), .align_req(align_req), .din_vld(din_vld),
    .din(din), .dout_vld(dout_vld), .dout(dout), .aligned(aligned)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b, bit req = 0);
    int pend;
    logic [7:0] w;
    pend = q.size();
    for (int i = 7; i >= 0; i--) q.push_back(b[i]);
    w = 8'h00;
    for (int i = 0; i < 8; i++) w = {w[6:0], q.pop_front()};
    @(negedge clk);
    din = w;
    din_vld = 1'b1;
    align_req = req;
    if (exp_on && !req) expq.push_back(pend > 0 ? last_tx : b);
    last_tx = b;
  endtask

  task automatic idle();
    @(negedge clk);
    din_vld = 1'b0;
    align_req = 1'b0;
  endtask

  task automatic check_al(bit e, string req);
    idle();
    chk(aligned == e, req, aligned, e);
  endtask

  task automatic filler(int n);
    for (int i = 0; i < n; i++) q.push_back(1'b0);
  endtask

  task automatic request();
    @(negedge clk);
    din_vld = 1'b0;
    align_req = 1'b1;
    check_al(1'b0, "R7");
  endtask

  always @(negedge clk) begin
    if (rst_n && dout_vld) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected byte", dout, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(dout == e, "R5", dout, e);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(aligned == 1'b0, "R1", aligned, 0);
    chk(dout_vld == 1'b0, "R1", dout_vld, 0);
    rst_n = 1'b1;
    check_al(1'b0, "R1");

    // shift of 3 bits, idle words produce nothing (R4)
    filler(3);
    send(8'hF0); send(8'hF0); send(8'hF0); send(8'h00);
    check_al(1'b0, "R4 idle");
    send(8'h00); send(8'h00);
    request();
    send(8'hF0); check_al(1'b0, "R3 first");
    send(8'hF0); check_al(1'b0, "R3 second");
    send(8'hF0); check_al(1'b0, "R3 third pending");
    send(8'h5A); check_al(1'b1, "R3 lock R2");
    exp_on = 1;
    send(8'h3C); send(8'h1E); send(8'h00); send(8'h0F);
    send(8'hF0); send(8'hA5);
    idle(); send(8'h81);
    check_al(1'b1, "R6");

    // request together with a word while locked
    send(8'h77, 1'b1);
    exp_on = 0;
    check_al(1'b0, "R7 same cycle");

    // shift of 6 bits, interrupted runs
    filler(3);
    send(8'h00); send(8'h00);
    send(8'hF0); send(8'hF0); send(8'h00);
    send(8'hF0); send(8'hF0); send(8'h00);
    check_al(1'b0, "R8");
    send(8'hF0); idle(); idle();
    send(8'hF0); idle();
    send(8'hF0); check_al(1'b0, "R9 pending");
    send(8'hC3); check_al(1'b1, "R9 lock across gaps");
    exp_on = 1;
    send(8'h12); idle(); send(8'hF0); send(8'h0F); idle(); idle(); send(8'hE1);
    check_al(1'b1, "R6 second");

    // whole-word shift
    request();
    exp_on = 0;
    filler(2);
    send(8'h00); send(8'h00);
    send(8'hF0); send(8'hF0); send(8'hF0); send(8'h99);
    check_al(1'b1, "R3 shift zero R2");
    exp_on = 1;
    send(8'h01); send(8'h80); send(8'hFF); send(8'h3E);

    repeat (3) idle();
    chk(expq.size() == 0, "R5 drained", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule